// File: doc/BRIEF.md
# Audio Sample FIFO Pair with DMA Request Thresholds

This block sits between a 32-bit data port and an audio serial engine. It has one FIFO for each direction. The data port pushes playback words into the transmit FIFO, and the serial engine pops them. The serial engine pushes captured words into the receive FIFO, and the data port pops them. Each side uses a simple one-cycle push or pop strobe. Popped words appear on a registered output one cycle after the pop.

Each FIFO compares its fill level against a programmable threshold and raises a DMA request while its enable is set:
- The transmit request is raised while the transmit FIFO is at or below its threshold.
- The receive request is raised while the receive FIFO is above its threshold.

Transmit underrun and receive overrun are latched as sticky flags, and a write-one-to-clear strobe clears them. These two flags and two level-based service conditions each have their own enable into a single interrupt output.

Each FIFO can be emptied by a self-clearing flush bit. A static strap selects between two flush arrangements:
- Independent: each FIFO has its own flush bit.
- Shared: the transmit flush bit empties both FIFOs, and the receive flush bit is ignored.

Top module: `audio_fifo_dma`

## Requirements
- R1: After a synchronous reset with `rst_n` low, the following hold:
  - both levels are 0;
  - both sticky flags are 0;
  - both flush bits are 0;
  - both popped-data outputs are 0;
  - the transmit threshold is 8 and the receive threshold is 7.
- R2: Each FIFO holds DEPTH (32) words and returns them in push order. A pop of a non-empty FIFO updates that side's data output at the next clock edge. `tx_level`/`rx_level` report the current entry count.
- R3: The following are ignored:
  - a data-port push to a full transmit FIFO (no level change, no flag);
  - a data-port pop of an empty receive FIFO (output unchanged, no flag).
- R4: A serial-engine pop of an empty transmit FIFO sets `tx_urun_flag` at the next edge and leaves `se_tx_data` at the previously popped word.
- R5: A serial-engine push to a full receive FIFO discards the word and sets `rx_orun_flag` at the next edge.
- R6: `stat_w1c[0]` clears the underrun flag and `stat_w1c[1]` clears the overrun flag at the next edge. A new event in the same cycle wins over the clear.
- R7: `tx_dreq` is high exactly when `tx_dma_en` is 1 and `tx_level` is less than or equal to the transmit threshold.
- R8: `rx_dreq` is high exactly when `rx_dma_en` is 1 and `rx_level` is greater than the receive threshold.
- R9: With `thr_we` high, both thresholds load from `thr_tx_in`/`thr_rx_in` at the next edge. Otherwise they hold their values.
- R10: A flush proceeds in three edges:
  - a flush strobe sets that flush bit at the next edge;
  - the FIFO is empty after the following edge;
  - the bit clears one edge later.

  While the bit is high, pushes and pops to that FIFO are ignored, and new strobes are ignored.
- R11: With `cfg_shared_flush` = 1, the transmit flush bit empties both FIFOs, and `rx_flush_set` has no effect (the receive flush bit stays 0). With the strap at 0, each flush touches only its own FIFO.
- R12: `irq` is the OR of four terms, each gated by its enable:
  - `tx_urun_flag` with `ie_tx_urun`;
  - `rx_orun_flag` with `ie_rx_orun`;
  - the transmit service condition (level at or below threshold) with `ie_tx_serv`;
  - the receive service condition (level above threshold) with `ie_rx_serv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shared_flush | input | 1 | Strap: 1 = transmit flush empties both FIFOs |
| dp_push | input | 1 | Data port writes a word into the transmit FIFO |
| dp_wdata | input | 32 | Data port write word |
| dp_pop | input | 1 | Data port reads a word from the receive FIFO |
| dp_rdata | output | 32 | Last word popped from the receive FIFO |
| se_tx_pop | input | 1 | Serial engine takes a word from the transmit FIFO |
| se_tx_data | output | 32 | Last word popped from the transmit FIFO |
| se_rx_push | input | 1 | Serial engine delivers a captured word |
| se_rx_data | input | 32 | Captured word |
| tx_dma_en | input | 1 | Enable for the transmit DMA request |
| rx_dma_en | input | 1 | Enable for the receive DMA request |
| ie_tx_urun | input | 1 | Interrupt enable, transmit underrun |
| ie_rx_orun | input | 1 | Interrupt enable, receive overrun |
| ie_tx_serv | input | 1 | Interrupt enable, transmit service |
| ie_rx_serv | input | 1 | Interrupt enable, receive service |
| thr_we | input | 1 | Load both thresholds |
| thr_tx_in | input | 5 | New transmit threshold |
| thr_rx_in | input | 5 | New receive threshold |
| tx_flush_set | input | 1 | Strobe that requests a transmit flush |
| rx_flush_set | input | 1 | Strobe that requests a receive flush |
| stat_w1c | input | 2 | Write-one-to-clear: bit0 underrun, bit1 overrun |
| tx_flush_bit | output | 1 | Transmit flush in progress |
| rx_flush_bit | output | 1 | Receive flush in progress |
| tx_level | output | 6 | Transmit FIFO entry count |
| rx_level | output | 6 | Receive FIFO entry count |
| tx_urun_flag | output | 1 | Sticky transmit underrun |
| rx_orun_flag | output | 1 | Sticky receive overrun |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
Assertions check the following on every cycle:
- the level bound;
- that an asserted flush leaves the FIFO empty;
- that the flush bit lasts exactly two cycles;
- that a shared flush also empties the receive FIFO;
- that underrun and overrun events latch their flags;
- that a write-one-to-clear without a new event clears them.

Word ordering, dropped pushes at full, the held output on an empty pop, threshold reloads and the interrupt combination depend on sequences of traffic. Only the bench's behavioural queue model, compared on every clock through filling, draining, flush and random mixed traffic, can show these.

// File: rtl/afd_pkg.sv
// Package: shared types and helpers for the audio FIFO pair.
// Assumes: nothing beyond SystemVerilog 2017.
package afd_pkg;

    // Flush sequencer state: idle, clearing the FIFO, then one cycle of done.
    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_CLEAR = 2'd1,
        FL_DONE  = 2'd2
    } flush_st_e;

    // Index of each channel in per-direction arrays.
    localparam int CH_TX = 0;
    localparam int CH_RX = 1;
    localparam int N_CH  = 2;

endpackage

// File: rtl/afd_fifo.sv
// Module: afd_fifo
// A synchronous FIFO with a registered pop output and a flush input.
// Behaviour:
//   - Pushes to a full FIFO and pops from an empty FIFO are refused.
//   - A refused pop leaves rdata unchanged.
//   - While flush is high, the pointers are cleared and push/pop are ignored.
// Assumes: DEPTH >= 2; the caller sees the full/empty flags for the current cycle.
module afd_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    // Status derived from the entry count.
    always_comb begin
        full    = (level == CW'(DEPTH));
        empty   = (level == '0);
        push_ok = push && !full && !flush;
        pop_ok  = pop && !empty && !flush;
    end

    // Storage write; memory contents need no reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and level bookkeeping, with flush clearing both pointers.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Registered pop output; it holds the last popped word on a refused pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (pop_ok) rdata <= mem[rd_ptr];
    end

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

    // R4
    hold_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(rdata));

endmodule

// File: rtl/afd_flush_ctl.sv
// Module: afd_flush_ctl
// Runs one self-clearing flush bit per direction.
// Sequence: a strobe moves the channel to CLEAR (bit high); CLEAR moves to
// DONE (bit still high); DONE returns to IDLE (bit low).
// In shared mode, the receive strobe is ignored and the transmit bit also
// flushes the receive FIFO.
// Assumes: cfg_shared only changes while both channels are idle.
module afd_flush_ctl
    import afd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_shared,
    input  logic [N_CH-1:0] set_strobe,
    output logic [N_CH-1:0] flush_bit,
    output logic [N_CH-1:0] fifo_flush
);

    logic [N_CH-1:0] set_eff;

    // Gate the receive strobe out in shared mode.
    always_comb begin
        set_eff        = set_strobe;
        set_eff[CH_RX] = set_strobe[CH_RX] && !cfg_shared;
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        flush_st_e st;

        // Three-step flush sequencer for one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) st <= FL_IDLE;
            else begin
                case (st)
                    FL_IDLE:  if (set_eff[c]) st <= FL_CLEAR;
                    FL_CLEAR: st <= FL_DONE;
                    default:  st <= FL_IDLE;
                endcase
            end
        end

        assign flush_bit[c] = (st != FL_IDLE);

        // R10
        flush_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flush_bit[c]) |=> flush_bit[c]);

        // R10
        flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_bit[c] && $past(flush_bit[c])) |=> !flush_bit[c]);
    end

    // Route the flush bits to the FIFOs; in shared mode the transmit bit
    // also drives the receive FIFO.
    always_comb begin
        fifo_flush[CH_TX] = flush_bit[CH_TX];
        fifo_flush[CH_RX] = flush_bit[CH_RX] || (cfg_shared && flush_bit[CH_TX]);
    end

    // R11
    shared_rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_shared && !flush_bit[CH_RX]) |=> !$rose(flush_bit[CH_RX]));

endmodule

// File: rtl/afd_status.sv
// Module: afd_status
// Holds the thresholds and the sticky underrun/overrun flags, and forms the
// DMA requests and the combined interrupt.
// Assumes: empty/full/flush inputs describe the FIFO state in the same cycle
// as the strobes.
module afd_status #(
    parameter int CW         = 6,
    parameter int THR_W      = 5,
    parameter int TX_THR_RST = 8,
    parameter int RX_THR_RST = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_pop,
    input  logic             tx_empty,
    input  logic             tx_flush,
    input  logic             rx_push,
    input  logic             rx_full,
    input  logic             rx_flush,
    input  logic [1:0]       w1c,
    input  logic [CW-1:0]    tx_level,
    input  logic [CW-1:0]    rx_level,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_tx_in,
    input  logic [THR_W-1:0] thr_rx_in,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    input  logic             ie_tx_urun,
    input  logic             ie_rx_orun,
    input  logic             ie_tx_serv,
    input  logic             ie_rx_serv,
    output logic             urun_flag,
    output logic             orun_flag,
    output logic             tx_dreq,
    output logic             rx_dreq,
    output logic             irq
);

    localparam int LW = (CW > THR_W) ? CW : THR_W;

    logic [THR_W-1:0] tx_thr, rx_thr;
    logic             urun_ev, orun_ev;
    logic             tx_serv, rx_serv;

    // Event detection on refused transfers outside a flush.
    always_comb begin
        urun_ev = tx_pop && tx_empty && !tx_flush;
        orun_ev = rx_push && rx_full && !rx_flush;
    end

    // Threshold registers with their reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= THR_W'(TX_THR_RST);
            rx_thr <= THR_W'(RX_THR_RST);
        end else if (thr_we) begin
            tx_thr <= thr_tx_in;
            rx_thr <= thr_rx_in;
        end
    end

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            urun_flag <= 1'b0;
            orun_flag <= 1'b0;
        end else begin
            urun_flag <= urun_ev || (urun_flag && !w1c[0]);
            orun_flag <= orun_ev || (orun_flag && !w1c[1]);
        end
    end

    // Level comparisons, DMA requests and the interrupt.
    always_comb begin
        tx_serv = LW'(tx_level) <= LW'(tx_thr);
        rx_serv = LW'(rx_level) >  LW'(rx_thr);
        tx_dreq = tx_dma_en && tx_serv;
        rx_dreq = rx_dma_en && rx_serv;
        irq     = (urun_flag && ie_tx_urun) || (orun_flag && ie_rx_orun) ||
                  (tx_serv && ie_tx_serv)   || (rx_serv && ie_rx_serv);
    end

    // R4
    urun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pop && tx_empty && !tx_flush) |=> urun_flag);

    // R5
    orun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full && !rx_flush) |=> orun_flag);

    // R6
    urun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[0] && !(tx_pop && tx_empty)) |=> !urun_flag);

    // R6
    orun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c[1] && !(rx_push && rx_full)) |=> !orun_flag);

endmodule

// File: rtl/audio_fifo_dma.sv
// Module: audio_fifo_dma
// Top level of the audio FIFO pair.
// The transmit FIFO is fed by the data port and drained by the serial engine.
// The receive FIFO is fed by the serial engine and drained by the data port.
// Threshold DMA requests, sticky error flags, flush control and the combined
// interrupt are built around the two FIFOs.
// Assumes: cfg_shared_flush is static while a flush is in progress.
module audio_fifo_dma
    import afd_pkg::*;
#(
    parameter int DW         = 32,
    parameter int DEPTH      = 32,
    parameter int THR_W      = 5,
    parameter int TX_THR_RST = 8,
    parameter int RX_THR_RST = 7,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shared_flush,
    input  logic             dp_push,
    input  logic [DW-1:0]    dp_wdata,
    input  logic             dp_pop,
    output logic [DW-1:0]    dp_rdata,
    input  logic             se_tx_pop,
    output logic [DW-1:0]    se_tx_data,
    input  logic             se_rx_push,
    input  logic [DW-1:0]    se_rx_data,
    input  logic             tx_dma_en,
    input  logic             rx_dma_en,
    input  logic             ie_tx_urun,
    input  logic             ie_rx_orun,
    input  logic             ie_tx_serv,
    input  logic             ie_rx_serv,
    input  logic             thr_we,
    input  logic [THR_W-1:0] thr_tx_in,
    input  logic [THR_W-1:0] thr_rx_in,
    input  logic             tx_flush_set,
    input  logic             rx_flush_set,
    input  logic [1:0]       stat_w1c,
    output logic             tx_flush_bit,
    output logic             rx_flush_bit,
    output logic [CW-1:0]    tx_level,
    output logic [CW-1:0]    rx_level,
    output logic             tx_urun_flag,
    output logic             rx_orun_flag,
    output logic             tx_dreq,
    output logic             rx_dreq,
    output logic             irq
);

    logic [N_CH-1:0] fl_bit, fl_fifo;
    logic            tx_full, tx_empty, rx_full, rx_empty;

    afd_flush_ctl u_flush (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_shared (cfg_shared_flush),
        .set_strobe ({rx_flush_set, tx_flush_set}),
        .flush_bit  (fl_bit),
        .fifo_flush (fl_fifo)
    );

    assign tx_flush_bit = fl_bit[CH_TX];
    assign rx_flush_bit = fl_bit[CH_RX];

    afd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fl_fifo[CH_TX]),
        .push  (dp_push),
        .wdata (dp_wdata),
        .pop   (se_tx_pop),
        .rdata (se_tx_data),
        .level (tx_level),
        .full  (tx_full),
        .empty (tx_empty)
    );

    afd_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (fl_fifo[CH_RX]),
        .push  (se_rx_push),
        .wdata (se_rx_data),
        .pop   (dp_pop),
        .rdata (dp_rdata),
        .level (rx_level),
        .full  (rx_full),
        .empty (rx_empty)
    );

    afd_status #(
        .CW(CW), .THR_W(THR_W), .TX_THR_RST(TX_THR_RST), .RX_THR_RST(RX_THR_RST)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_pop     (se_tx_pop),
        .tx_empty   (tx_empty),
        .tx_flush   (fl_fifo[CH_TX]),
        .rx_push    (se_rx_push),
        .rx_full    (rx_full),
        .rx_flush   (fl_fifo[CH_RX]),
        .w1c        (stat_w1c),
        .tx_level   (tx_level),
        .rx_level   (rx_level),
        .thr_we     (thr_we),
        .thr_tx_in  (thr_tx_in),
        .thr_rx_in  (thr_rx_in),
        .tx_dma_en  (tx_dma_en),
        .rx_dma_en  (rx_dma_en),
        .ie_tx_urun (ie_tx_urun),
        .ie_rx_orun (ie_rx_orun),
        .ie_tx_serv (ie_tx_serv),
        .ie_rx_serv (ie_rx_serv),
        .urun_flag  (tx_urun_flag),
        .orun_flag  (rx_orun_flag),
        .tx_dreq    (tx_dreq),
        .rx_dreq    (rx_dreq),
        .irq        (irq)
    );

    // R11
    shared_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_shared_flush && tx_flush_bit) |=> (rx_level == '0));

    // R3
    rx_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_pop && rx_empty && !se_rx_push) |=> (rx_level == '0) && $stable(dp_rdata));

endmodule

// File: tb/tb_audio_fifo_dma.sv
module tb_audio_fifo_dma;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_shared_flush = 1'b0;
    logic        dp_push = 1'b0, dp_pop = 1'b0, se_tx_pop = 1'b0, se_rx_push = 1'b0;
    logic [31:0] dp_wdata = '0, se_rx_data = '0;
    logic        tx_dma_en = 1'b0, rx_dma_en = 1'b0;
    logic        ie_tx_urun = 1'b0, ie_rx_orun = 1'b0, ie_tx_serv = 1'b0, ie_rx_serv = 1'b0;
    logic        thr_we = 1'b0;
    logic [4:0]  thr_tx_in = '0, thr_rx_in = '0;
    logic        tx_flush_set = 1'b0, rx_flush_set = 1'b0;
    logic [1:0]  stat_w1c = '0;
    logic [31:0] dp_rdata, se_tx_data;
    logic        tx_flush_bit, rx_flush_bit, tx_urun_flag, rx_orun_flag;
    logic        tx_dreq, rx_dreq, irq;
    logic [5:0]  tx_level, rx_level;

    always #4 clk = ~clk;

    audio_fifo_dma dut (.*);

    int checks = 0, failures = 0;
    int cyc = 0;

    // Behavioural reference model
    int unsigned txq[$], rxq[$];
    logic [31:0] m_txout = '0, m_rxout = '0;
    bit m_urun = 0, m_orun = 0;
    int m_txst = 0, m_rxst = 0;
    int m_txthr = 8, m_rxthr = 7;

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_txout = '0; m_rxout = '0; m_urun = 0; m_orun = 0;
            m_txst = 0; m_rxst = 0; m_txthr = 8; m_rxthr = 7;
        end else begin
            automatic bit txfl = (m_txst != 0);
            automatic bit rxfl = (m_rxst != 0) || (cfg_shared_flush && m_txst != 0);
            automatic int tsz = txq.size();
            automatic int rsz = rxq.size();
            automatic bit uev = 0, oev = 0;
            if (txfl) txq.delete();
            else begin
                if (se_tx_pop) begin
                    if (tsz == 0) uev = 1; else m_txout = txq.pop_front();
                end
                if (dp_push && tsz < DEPTH) txq.push_back(dp_wdata);
            end
            if (rxfl) rxq.delete();
            else begin
                if (dp_pop && rsz > 0) m_rxout = rxq.pop_front();
                if (se_rx_push) begin
                    if (rsz < DEPTH) rxq.push_back(se_rx_data); else oev = 1;
                end
            end
            m_urun = uev || (m_urun && !stat_w1c[0]);
            m_orun = oev || (m_orun && !stat_w1c[1]);
            if (m_txst == 2) m_txst = 0; else if (m_txst == 1) m_txst = 2;
            else if (tx_flush_set) m_txst = 1;
            if (m_rxst == 2) m_rxst = 0; else if (m_rxst == 1) m_rxst = 2;
            else if (rx_flush_set && !cfg_shared_flush) m_rxst = 1;
            if (thr_we) begin m_txthr = thr_tx_in; m_rxthr = thr_rx_in; end
        end
    end

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare all outputs against the model (called away from the edge).
    task automatic compare();
        automatic bit ts = txq.size() <= m_txthr;
        automatic bit rs = rxq.size() > m_rxthr;
        check("R2 tx_level", tx_level, txq.size());
        check("R2 rx_level", rx_level, rxq.size());
        check("R2 dp_rdata", dp_rdata, m_rxout);
        check("R4 se_tx_data", se_tx_data, m_txout);
        check("R4 tx_urun_flag", tx_urun_flag, m_urun);
        check("R5 rx_orun_flag", rx_orun_flag, m_orun);
        check("R7 tx_dreq", tx_dreq, tx_dma_en && ts);
        check("R8 rx_dreq", rx_dreq, rx_dma_en && rs);
        check("R10 tx_flush_bit", tx_flush_bit, m_txst != 0);
        check("R10 rx_flush_bit", rx_flush_bit, m_rxst != 0);
        check("R12 irq", irq, (m_urun && ie_tx_urun) || (m_orun && ie_rx_orun) ||
                              (ts && ie_tx_serv) || (rs && ie_rx_serv));
    endtask

    // One clock: edge, then settle to negedge, then compare.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle_inputs();
        dp_push = 0; dp_pop = 0; se_tx_pop = 0; se_rx_push = 0;
        tx_flush_set = 0; rx_flush_set = 0; stat_w1c = '0; thr_we = 0;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        tx_dma_en = 1; rx_dma_en = 1;
        #1;
        check("R1 tx_level", tx_level, 0);
        check("R1 rx_level", rx_level, 0);
        check("R1 flags", {tx_urun_flag, rx_orun_flag}, 0);
        check("R1 flush bits", {tx_flush_bit, rx_flush_bit}, 0);
        check("R1 data outs", {dp_rdata, se_tx_data}, 0);
        check("R1 tx_dreq at default thr", tx_dreq, 1);
        check("R1 rx_dreq at default thr", rx_dreq, 0);
        @(negedge clk);

        // Fill tx with 34 words: two are dropped (R3)
        for (int i = 0; i < 34; i++) begin
            dp_push = 1; dp_wdata = 32'hA000_0000 + i;
            tick();
        end
        idle_inputs();
        check("R3 tx full push dropped", tx_level, DEPTH);
        check("R3 no flag on full tx push", tx_urun_flag, 0);

        // Drain tx with 34 pops: two underruns (R4)
        ie_tx_urun = 1;
        for (int i = 0; i < 34; i++) begin
            se_tx_pop = 1;
            tick();
        end
        idle_inputs();
        check("R4 underrun latched", tx_urun_flag, 1);
        check("R4 last word held", se_tx_data, 32'hA000_001F);
        tick();

        // R6: clear with simultaneous new event -> event wins; then plain clear
        stat_w1c = 2'b01; se_tx_pop = 1; tick();
        check("R6 set beats clear", tx_urun_flag, 1);
        se_tx_pop = 0; tick();
        check("R6 w1c clears underrun", tx_urun_flag, 0);
        idle_inputs();

        // Fill rx with 33 pushes -> overrun (R5), drain via data port
        ie_rx_orun = 1;
        for (int i = 0; i < 33; i++) begin
            se_rx_push = 1; se_rx_data = 32'hB000_0000 + i;
            tick();
        end
        idle_inputs();
        check("R5 overrun latched", rx_orun_flag, 1);
        for (int i = 0; i < 34; i++) begin
            dp_pop = 1; tick();
        end
        idle_inputs();
        check("R3 rx empty pop keeps data", dp_rdata, 32'hB000_001F);
        check("R3 rx empty pop no level", rx_level, 0);
        stat_w1c = 2'b10; tick(); idle_inputs();
        check("R6 w1c clears overrun", rx_orun_flag, 0);

        // R9 threshold reload
        for (int i = 0; i < 5; i++) begin dp_push = 1; dp_wdata = i; tick(); end
        idle_inputs();
        thr_we = 1; thr_tx_in = 5'd4; thr_rx_in = 5'd0; tick(); idle_inputs();
        check("R9 tx_dreq above new thr", tx_dreq, 0);
        se_tx_pop = 1; tick(); idle_inputs();
        check("R9 tx_dreq at new thr", tx_dreq, 1);
        se_rx_push = 1; se_rx_data = 32'h55; tick(); idle_inputs();
        check("R9 rx_dreq above zero thr", rx_dreq, 1);

        // R10 separate flush of tx only
        tx_flush_set = 1; dp_push = 1; tick(); idle_inputs();
        check("R10 tx flush bit set", tx_flush_bit, 1);
        dp_push = 1; tick(); idle_inputs();
        check("R10 tx emptied", tx_level, 0);
        check("R11 rx untouched when separate", rx_level, 1);
        tick();
        check("R10 tx flush bit cleared", tx_flush_bit, 0);
        rx_flush_set = 1; tick(); idle_inputs(); tick(); tick();
        check("R10 rx emptied", rx_level, 0);

        // R11 shared flush
        cfg_shared_flush = 1;
        for (int i = 0; i < 3; i++) begin
            dp_push = 1; se_rx_push = 1; se_rx_data = i; tick();
        end
        idle_inputs();
        rx_flush_set = 1; tick(); idle_inputs();
        check("R11 rx strobe ignored in shared", rx_flush_bit, 0);
        check("R11 rx level kept", rx_level, 3);
        tx_flush_set = 1; tick(); idle_inputs(); tick();
        check("R11 shared empties tx", tx_level, 0);
        check("R11 shared empties rx", rx_level, 0);
        tick(); tick();
        cfg_shared_flush = 0;

        // R12 irq from service enables
        ie_tx_urun = 0; ie_rx_orun = 0; ie_tx_serv = 1; tick();
        check("R12 irq from tx service", irq, 1);
        ie_tx_serv = 0; ie_rx_serv = 1; tick();
        check("R12 irq rx service idle", irq, 0);
        thr_we = 1; thr_tx_in = 5'd8; thr_rx_in = 5'd7; tick(); idle_inputs();

        // Random mixed traffic with model compare every cycle
        ie_tx_urun = 1; ie_rx_orun = 1;
        for (int i = 0; i < 3000; i++) begin
            dp_push     = ($urandom % 3) != 0;
            dp_wdata    = $urandom;
            se_tx_pop   = ($urandom % 3) == 0;
            se_rx_push  = ($urandom % 2) == 0;
            se_rx_data  = $urandom;
            dp_pop      = ($urandom % 3) == 0;
            stat_w1c    = (($urandom % 16) == 0) ? 2'($urandom) : 2'b00;
            tx_flush_set = ($urandom % 97) == 0;
            rx_flush_set = ($urandom % 89) == 0;
            thr_we      = ($urandom % 200) == 0;
            thr_tx_in   = 5'($urandom);
            thr_rx_in   = 5'($urandom);
            tx_dma_en   = ($urandom % 5) != 0;
            ie_tx_serv  = ($urandom % 7) == 0;
            ie_rx_serv  = ($urandom % 7) == 0;
            tick();
        end
        idle_inputs();
        tick();
        finish_run();
    end

endmodule